// File: doc/BRIEF.md
# Back-Pressured Link Receive Buffer

This block terminates one point-to-point push link. The far-end source writes one 32-bit word per cycle. It keeps writing until it sees a single stop level, called `xoff`, that this block drives back toward it. The words go into a FIFO, and a separate consumer drains the FIFO through a show-ahead read port. The link has no per-word ready signal. The buffer keeps a skid reserve instead. `xoff` is raised once occupancy reaches `DEPTH - RTT_WORDS`, which leaves exactly enough free entries to take every word already in flight during the round trip of the stop signal.

`xoff` falls again only when occupancy drops below a lower mark (`LOW_MARK`), so the line does not toggle while the consumer drains slowly. Each instance throttles its own link and has no connection to other links. Any assertion of `xoff` means the upstream rate budget was exceeded, so it sets a sticky `throttleErr`. A word arriving when no entry is free is lost and sets a sticky `overflowErr`. Both flags clear only on reset.

Top module: `link_rx_buffer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `outValid`, `xoff`, `overflowErr` and `throttleErr` are all 0.
- R2: `outValid` is 1 exactly when occupancy is nonzero. While it is 1, `outData` shows the oldest stored word. Words leave in the order they were accepted.
- R3: A word with `inValid` high is accepted if occupancy is below `DEPTH`, or if a read is taken in the same cycle. Otherwise it is dropped and `overflowErr` goes to 1 at that clock edge and stays 1 until reset.
- R4: `xoff` goes to 1 at the clock edge where the updated occupancy becomes at least `DEPTH - RTT_WORDS`.
- R5: `xoff` goes to 0 at the edge where the updated occupancy becomes less than `LOW_MARK`. Between the two marks it keeps its previous value.
- R6: `throttleErr` goes to 1 at the same edge as the first assertion of `xoff` and stays 1 until reset.
- R7: A source that keeps writing every cycle and stops at most `RTT_WORDS` cycles after `xoff` rises never causes `overflowErr`, even when nothing is read.
- R8: `outRead` while `outValid` is 0 has no effect on occupancy, data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Source word strobe, no handshake |
| inData | input | 32 | Source word |
| xoff | output | 1 | Stop level toward the source |
| outRead | input | 1 | Consumer takes the head word |
| outValid | output | 1 | FIFO holds at least one word |
| outData | output | 32 | Head word (show-ahead) |
| overflowErr | output | 1 | Sticky: a word was dropped |
| throttleErr | output | 1 | Sticky: `xoff` was asserted |

## Verification
A drifting occupancy count would show up at the ports in one of three ways. `xoff` would rise or fall one or more cycles away from the edge the marks predict. `outValid` would disagree at the empty boundary. Or a dropped or duplicated word would appear at `outData` as soon as that entry reached the head. A pointer fault shows as wrong data on the first read that follows it. For that reason the reference queue is compared against all outputs on every cycle, so any fault is caught in the cycle it first reaches a port. The scenarios are chosen to walk occupancy across both marks, through full with a source that stops exactly on the reserve limit, and through full with a source that ignores `xoff`.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  // Strobes from the control side into the storage side.
  typedef struct packed {
    logic push;   // store inData at write pointer
    logic pop;    // advance read pointer
  } fifoStrobes_t;
endpackage

// File: rtl/link_rx_ctrl.sv
module link_rx_ctrl
  import link_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RTT_WORDS = 4,
  parameter int LOW_MARK  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         outRead,
  output fifoStrobes_t strobes,
  output logic [CW-1:0] occ,
  output logic         xoff,
  output logic         overflowErr,
  output logic         throttleErr
);
  localparam logic [CW-1:0] FullLvl = CW'(DEPTH);
  localparam logic [CW-1:0] HighLvl = CW'(DEPTH - RTT_WORDS);
  localparam logic [CW-1:0] LowLvl  = CW'(LOW_MARK);

  logic [CW-1:0] occNext;
  logic          xoffNext;
  logic          dropNow;
  logic          notEmpty;

  assign notEmpty = (occ != '0);

  always_comb begin
    strobes.pop  = outRead && notEmpty;
    strobes.push = inValid && ((occ != FullLvl) || strobes.pop);
    dropNow      = inValid && !strobes.push;
    occNext      = occ + {{(CW-1){1'b0}}, strobes.push}
                       - {{(CW-1){1'b0}}, strobes.pop};
    if (occNext >= HighLvl)     xoffNext = 1'b1;
    else if (occNext < LowLvl)  xoffNext = 1'b0;
    else                        xoffNext = xoff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ         <= '0;
      xoff        <= 1'b0;
      overflowErr <= 1'b0;
      throttleErr <= 1'b0;
    end else begin
      occ         <= occNext;
      xoff        <= xoffNext;
      overflowErr <= overflowErr | dropNow;
      throttleErr <= throttleErr | xoffNext;
    end
  end
endmodule

// File: rtl/link_rx_datapath.sv
module link_rx_datapath
  import link_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [AW-1:0]     wrPtrInc;
  logic [AW-1:0]     rdPtrInc;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wrPtrInc = wrPtr + 1'b1;
      assign rdPtrInc = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrPtrInc = (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrInc = (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtrInc;
      if (strobes.pop)  rdPtr <= rdPtrInc;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= inData;
  end

  assign outData = store[rdPtr];
endmodule

// File: rtl/link_rx_buffer.sv
module link_rx_buffer
  import link_rx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int RTT_WORDS = 4,
  parameter int LOW_MARK  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              xoff,
  input  logic              outRead,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              overflowErr,
  output logic              throttleErr
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobes_t  strobes;
  logic [CW-1:0] occ;

  link_rx_ctrl #(
    .DEPTH(DEPTH), .RTT_WORDS(RTT_WORDS), .LOW_MARK(LOW_MARK)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outRead(outRead),
    .strobes(strobes), .occ(occ), .xoff(xoff),
    .overflowErr(overflowErr), .throttleErr(throttleErr)
  );

  link_rx_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .inData(inData), .outData(outData)
  );

  assign outValid = (occ != '0);
endmodule

// File: rtl/link_rx_buffer_chk.sv
module link_rx_buffer_chk #(
  parameter int DEPTH     = 16,
  parameter int RTT_WORDS = 4,
  parameter int LOW_MARK  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inValid,
  input logic          outRead,
  input logic          xoff,
  input logic          overflowErr,
  input logic          throttleErr,
  input logic [CW-1:0] occ
);
  // R3
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !outRead && occ == CW'(DEPTH)) |=> overflowErr);
  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |=> overflowErr);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R4
  xoff_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff) |-> occ >= CW'(DEPTH - RTT_WORDS));
  // R5
  xoff_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff) |-> occ < CW'(LOW_MARK));
  // R6
  throttle_follows_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff |-> throttleErr);
  // R6
  throttle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    throttleErr |=> throttleErr);
endmodule

bind link_rx_buffer link_rx_buffer_chk #(
  .DEPTH(DEPTH), .RTT_WORDS(RTT_WORDS), .LOW_MARK(LOW_MARK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .outRead(outRead),
  .xoff(xoff), .overflowErr(overflowErr), .throttleErr(throttleErr),
  .occ(occ)
);

// File: tb/link_rx_buffer_tb_top.sv
module link_rx_buffer_tb_top;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int RTT    = 4;
  localparam int LOWM   = 8;
  localparam int HIGHM  = DEPTH - RTT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic outRead = 1'b0;
  logic xoff, outValid, overflowErr, throttleErr;
  logic [DATA_W-1:0] outData;

  always #4 clk = ~clk;

  link_rx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RTT_WORDS(RTT), .LOW_MARK(LOWM))
  dut_i (.clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData), .xoff(xoff),
         .outRead(outRead), .outValid(outValid), .outData(outData),
         .overflowErr(overflowErr), .throttleErr(throttleErr));

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [DATA_W-1:0] mq[$];
  bit mXoff, mOvf, mThr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mXoff = 0; mOvf = 0; mThr = 0;
    end else begin
      bit pop, push;
      pop  = outRead && (mq.size() > 0);
      push = inValid && ((mq.size() < DEPTH) || pop);
      if (inValid && !push) mOvf = 1;
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(inData);
      if (mq.size() >= HIGHM) mXoff = 1;
      else if (mq.size() < LOWM) mXoff = 0;
      if (mXoff) mThr = 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // stimulus controls
  bit srcRun = 0, srcIgnore = 0, srcGap = 0;
  int rdMode = 0;  // 0 off, 1 every cycle, 2 every 4th cycle, 3 every cycle even if empty
  logic [RTT:0] xHist = '0;
  int cyc = 0;
  logic [DATA_W-1:0] word = 32'hA5000000;

  always @(negedge clk) begin
    cyc++;
    // compare to model on every cycle
    check(outValid == (mq.size() > 0), "R2 outValid", 64'(outValid), 64'(mq.size() > 0));
    if (mq.size() > 0)
      check(outData == mq[0], "R2 outData", 64'(outData), 64'(mq[0]));
    check(xoff == mXoff, "R4 R5 xoff", 64'(xoff), 64'(mXoff));
    check(overflowErr == mOvf, "R3 overflowErr", 64'(overflowErr), 64'(mOvf));
    check(throttleErr == mThr, "R6 throttleErr", 64'(throttleErr), 64'(mThr));
    // source model with reaction delay RTT
    xHist = {xHist[RTT-1:0], xoff};
    inValid = srcRun && (srcIgnore || !xHist[RTT]) && !(srcGap && cyc[0]);
    if (inValid) begin word = word + 32'h01010001; inData = word; end
    case (rdMode)
      1: outRead = outValid;
      2: outRead = outValid && (cyc % 4 == 0);
      3: outRead = 1'b1;
      default: outRead = 1'b0;
    endcase
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    waitCyc(3);
    #1;
    // R1: reset values while held
    check(!outValid && !xoff && !overflowErr && !throttleErr, "R1 reset",
          64'({outValid, xoff, overflowErr, throttleErr}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!outValid && !xoff && !overflowErr && !throttleErr, "R1 after release",
          64'({outValid, xoff, overflowErr, throttleErr}), 64'(0));

    // R8: reads of empty buffer
    @(posedge clk); rdMode = 3;
    waitCyc(5);
    @(posedge clk); rdMode = 0;
    @(negedge clk); #1;
    check(!outValid && !overflowErr, "R8 empty read", 64'({outValid, overflowErr}), 64'(0));

    // R2: trickle with gaps, concurrent drain
    @(posedge clk); srcRun = 1; srcGap = 1; rdMode = 2;
    waitCyc(40);
    @(posedge clk); srcRun = 0; srcGap = 0; rdMode = 1;
    waitCyc(30);
    @(negedge clk); #1;
    check(!outValid, "R2 drained", 64'(outValid), 64'(0));

    // R4 R7: full-rate source, no reader, reaction delay equal to reserve
    @(posedge clk); rdMode = 0; srcRun = 1;
    waitCyc(40);
    @(negedge clk); #1;
    check(xoff == 1, "R4 xoff high when filled", 64'(xoff), 64'(1));
    check(overflowErr == 0, "R7 reserve absorbs in-flight words", 64'(overflowErr), 64'(0));
    check(throttleErr == 1, "R6 throttle flag", 64'(throttleErr), 64'(1));

    // R5: slow drain across hysteresis band, source resumes when released
    @(posedge clk); rdMode = 2;
    waitCyc(80);
    @(posedge clk); srcRun = 0; rdMode = 1;
    waitCyc(30);
    @(negedge clk); #1;
    check(xoff == 0, "R5 xoff low after drain", 64'(xoff), 64'(0));
    check(throttleErr == 1, "R6 throttle stays", 64'(throttleErr), 64'(1));

    // R3: fill, then write+read while full, then write while full with no read
    @(posedge clk); rdMode = 0; srcRun = 1;
    waitCyc(30);
    @(posedge clk); srcIgnore = 1; rdMode = 1;
    waitCyc(10);
    @(negedge clk); #1;
    check(overflowErr == 0, "R3 read-while-full accepts", 64'(overflowErr), 64'(0));
    @(posedge clk); rdMode = 0;
    waitCyc(4);
    @(negedge clk); #1;
    check(overflowErr == 1, "R3 drop sets flag", 64'(overflowErr), 64'(1));
    @(posedge clk); srcRun = 0; srcIgnore = 0; rdMode = 1;
    waitCyc(30);
    @(negedge clk); #1;
    check(overflowErr == 1 && !outValid, "R3 flag sticky", 64'({overflowErr, outValid}), 64'(2));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule